// File: doc/BRIEF.md
# Receive FIFO with Trigger and Flow-Control Thresholds

This block is the receive side of a FIFO-buffered serial port. Bytes from the deserialiser arrive with a one-cycle valid strobe and are queued in a 16-entry FIFO. Software takes bytes out through a read strobe and sees the oldest byte on a data port at all times. A byte that arrives while all 16 entries are taken is thrown away and a sticky overrun flag is raised. Software reads that flag through a status read strobe, and the read clears it.

Two threshold fields sit in one 12-bit control register. The trigger field (bits 8:7) picks how many bytes make the FIFO count as "full enough": codes 0, 1, 2 and 3 mean 1, 4, 8 and 14 bytes. A three-state machine follows the FIFO level against that threshold. Its states are EMPTY (no data), BELOW (data present, under the trigger) and AT_TRIGGER (level at or above the trigger). Its transitions are: EMPTY to BELOW and EMPTY to AT_TRIGGER when data arrives, BELOW to AT_TRIGGER when the level reaches the trigger, AT_TRIGGER to BELOW when reads take it under the trigger, BELOW to EMPTY and AT_TRIGGER to EMPTY when the FIFO drains or is cleared, and a hold in every state when the class does not change. The machine loads its next state from the level and the trigger code that will hold after the current edge. Its flags are therefore valid in the same cycle as the new level.

The flow-control field (bits 11:9) picks the level at which the far end must stop sending. Codes 0 to 7 map to 15, 1, 4, 6, 8, 10, 12 and 14. Bit 1 of the control register is a self-clearing command that empties the FIFO.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset the level is 0, the full and data-ready flags are 0, the overrun flag is 0, the control register reads 0 and accept_ok is 1.
- R2: The FIFO holds up to 16 bytes. rd_data shows the oldest byte whenever the FIFO is not empty. A cycle with rd_req high and a non-empty FIFO removes that byte, so bytes come out in arrival order.
- R3: A byte whose rx_valid cycle finds the level at 16 is discarded and the level stays 16. From the next cycle on, the overrun flag reads 1.
- R4: Control bits 8:7 select the trigger level: code 0 is 1 byte, code 1 is 4 bytes, code 2 is 8 bytes and code 3 is 14 bytes.
- R5: When the level is at or above the trigger, rx_full is 1 and data_ready is 0. When the level is below it, rx_full is 0 and data_ready is 1 exactly when the level is nonzero. Both flags change at the same clock edge as the level.
- R6: Control bits 11:9 select the flow threshold: codes 0 to 7 map to 15, 1, 4, 6, 8, 10, 12 and 14. accept_ok is 1 exactly while the level is below that threshold.
- R7: lsr_overrun shows the overrun flag during a cycle with lsr_rd high, and the flag reads 0 from the next cycle on. If an overrun happens in the same cycle as the read, the flag stays 1.
- R8: A cycle that both adds a byte and removes one leaves the level unchanged.
- R9: A control write with bit 1 set empties the FIFO at that edge, and it also drops a byte arriving in that cycle. The flags follow the empty level at the same edge, and bit 1 always reads back as 0.
- R10: rd_data is 0 while the FIFO is empty. A read strobe on an empty FIFO changes nothing, so the next byte written is the next byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Byte from the deserialiser |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| rd_req | input | 1 | Remove the byte shown on rd_data |
| rd_data | output | 8 | Oldest queued byte, 0 when empty |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 12 | Control write value |
| ctrl_rdata | output | 12 | Control register contents |
| lsr_rd | input | 1 | Line-status read strobe, clears overrun |
| lsr_overrun | output | 1 | Sticky overrun flag |
| rx_level | output | 5 | Number of queued bytes, 0 to 16 |
| rx_full | output | 1 | Level at or above trigger |
| data_ready | output | 1 | Data present below trigger |
| accept_ok | output | 1 | Far end may keep sending |

## Verification
The assertions assume that rx_valid, rd_req, ctrl_wr and lsr_rd are single-cycle strobes sampled at the rising edge. They also assume the control value only changes through ctrl_wr, so the flags can be compared with the level and the registered trigger code. The stimulus drives every input at the falling edge and returns each strobe to 0 one cycle later. The sweep walks all 32 pairs of trigger and flow codes, each from empty to 16 bytes and back. The overrun, clear, empty-read and add-and-remove cases run as separate sequences after the sweep.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        FL_EMPTY    = 2'd0,
        FL_BELOW    = 2'd1,
        FL_AT_TRIG  = 2'd2
    } fl_state_e;

    localparam int CLR_BIT  = 1;
    localparam int TRIG_LSB = 7;
    localparam int FC_LSB   = 9;

    function automatic int unsigned trig_of(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int unsigned flow_of(input logic [2:0] code);
        case (code)
            3'd0:    return 15;
            3'd1:    return 1;
            default: return 2 * int'(code);
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_comb begin
        if (clr)
            count_nxt = '0;
        else
            count_nxt = count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            count <= count_nxt;
            if (clr) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (push) wptr <= wptr + 1'b1;
                if (pop)  rptr <= rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wptr] <= wdata;
    end

    assign rdata = (count != '0) ? mem[rptr] : '0;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R2
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clr) |=> $stable(count)); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R9
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (rdata == '0)); // R10

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_nxt,
    input  logic [CW-1:0] trig_nxt,
    output logic          full_flag,
    output logic          ready_flag
);

    fl_state_e st_q, st_d;

    always_comb begin
        if (count_nxt == '0)
            st_d = FL_EMPTY;
        else if (count_nxt >= trig_nxt)
            st_d = FL_AT_TRIG;
        else
            st_d = FL_BELOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        full_flag  = 1'b0;
        ready_flag = 1'b0;
        unique case (st_q)
            FL_EMPTY:   ;
            FL_BELOW:   ready_flag = 1'b1;
            FL_AT_TRIG: full_flag  = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
    import rxq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int CTRL_W = 12,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     rx_byte,
    input  logic              rx_valid,
    input  logic              rd_req,
    output logic [DW-1:0]     rd_data,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              lsr_rd,
    output logic              lsr_overrun,
    output logic [CW-1:0]     rx_level,
    output logic              rx_full,
    output logic              data_ready,
    output logic              accept_ok
);

    logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
    logic              clr, push, pop, level_max, ovr_evt, ovr_q;
    logic [CW-1:0]     count, count_nxt, trig_nxt, trig_cur, flow_cur;

    assign clr      = ctrl_wr && ctrl_wdata[CLR_BIT];
    assign ctrl_nxt = ctrl_wr ? (ctrl_wdata & ~(CTRL_W'(1) << CLR_BIT)) : ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_nxt;
    end

    assign level_max = (count == CW'(DEPTH));
    assign push      = rx_valid && !level_max && !clr;
    assign pop       = rd_req && (count != '0) && !clr;
    assign ovr_evt   = rx_valid && level_max;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (ovr_evt) ovr_q <= 1'b1;
        else if (lsr_rd)  ovr_q <= 1'b0;
    end

    assign trig_nxt = CW'(trig_of(ctrl_nxt[TRIG_LSB +: 2]));
    assign trig_cur = CW'(trig_of(ctrl_q[TRIG_LSB +: 2]));
    assign flow_cur = CW'(flow_of(ctrl_q[FC_LSB +: 3]));

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .clr       (clr),
        .wdata     (rx_byte),
        .rdata     (rd_data),
        .count     (count),
        .count_nxt (count_nxt)
    );

    rxq_flags #(.CW(CW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_nxt  (count_nxt),
        .trig_nxt   (trig_nxt),
        .full_flag  (rx_full),
        .ready_flag (data_ready)
    );

    assign accept_ok   = (count < flow_cur);
    assign rx_level    = count;
    assign ctrl_rdata  = ctrl_q;
    assign lsr_overrun = ovr_q;

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> lsr_overrun); // R3
    AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !ovr_evt) |=> !lsr_overrun); // R7
    AST_FULL_AT_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> (rx_level >= trig_cur)); // R5
    AST_READY_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> (rx_level != '0 && rx_level < trig_cur)); // R5
    AST_NO_LOSS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && level_max && !rd_req && !clr) |=> (rx_level == CW'(DEPTH))); // R3

endmodule

// File: tb/rx_fifo_trig_test.sv
module rx_fifo_trig_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0, rd_req = 1'b0, ctrl_wr = 1'b0, lsr_rd = 1'b0;
    logic [11:0] ctrl_wdata = '0;
    logic [7:0]  rd_data;
    logic [11:0] ctrl_rdata;
    logic        lsr_overrun, rx_full, data_ready, accept_ok;
    logic [4:0]  rx_level;

    always #10 clk = ~clk;

    rx_fifo_trig uut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rd_req(rd_req), .rd_data(rd_data), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .lsr_rd(lsr_rd),
        .lsr_overrun(lsr_overrun), .rx_level(rx_level), .rx_full(rx_full),
        .data_ready(data_ready), .accept_ok(accept_ok)
    );

    int checks = 0;
    int fails = 0;
    int cur_tc = 0;
    int cur_fc = 0;
    logic [7:0] mq [$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int trig_lv(input int c);
        return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
    endfunction

    function automatic int flow_lv(input int c);
        return (c == 0) ? 15 : (c == 1) ? 1 : 2 * c;
    endfunction

    task automatic check_all(input string tag);
        int n = mq.size();
        int f = (n >= trig_lv(cur_tc)) ? 1 : 0;
        chk({tag, " R2 level"}, int'(rx_level), n);
        chk({tag, " R4 R5 full"}, int'(rx_full), f);
        chk({tag, " R5 ready"}, int'(data_ready), (f == 0 && n != 0) ? 1 : 0);
        chk({tag, " R6 accept"}, int'(accept_ok), (n < flow_lv(cur_fc)) ? 1 : 0);
        chk({tag, " R2 R10 data"}, int'(rd_data), (n != 0) ? int'(mq[0]) : 0);
    endtask

    task automatic push_b(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        if (mq.size() < 16) mq.push_back(b);
    endtask

    task automatic pop_b();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
    endtask

    task automatic wr_ctrl(input logic [11:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
        if (v[1]) mq.delete();
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", int'(rx_level), 0);
        chk("R1 full", int'(rx_full), 0);
        chk("R1 ready", int'(data_ready), 0);
        chk("R1 overrun", int'(lsr_overrun), 0);
        chk("R1 ctrl", int'(ctrl_rdata), 0);
        chk("R1 accept", int'(accept_ok), 1);

        // R4 R5 R6: sweep every trigger and flow code through all levels
        for (int tc = 0; tc < 4; tc++) begin
            for (int fc = 0; fc < 8; fc++) begin
                cur_tc = tc; cur_fc = fc;
                wr_ctrl(12'((fc << 9) | (tc << 7) | 2));
                chk("R9 clear bit reads 0", int'(ctrl_rdata[1]), 0);
                check_all("sweep empty");
                for (int k = 0; k < 16; k++) begin
                    push_b(8'((tc * 8 + fc) * 17 + k + 1));
                    check_all("sweep fill");
                end
                for (int k = 0; k < 16; k++) begin
                    pop_b();
                    check_all("sweep drain");
                end
            end
        end

        // R3 overrun and R7 status read
        cur_tc = 2; cur_fc = 4;
        wr_ctrl(12'((4 << 9) | (2 << 7) | 2));
        for (int k = 0; k < 16; k++) push_b(8'(k + 100));
        chk("R3 no overrun yet", int'(lsr_overrun), 0);
        push_b(8'hEE);
        chk("R3 overrun set", int'(lsr_overrun), 1);
        check_all("R3 byte dropped");
        lsr_rd = 1'b1;
        #1;
        chk("R7 read shows flag", int'(lsr_overrun), 1);
        @(negedge clk);
        lsr_rd = 1'b0;
        chk("R7 cleared by read", int'(lsr_overrun), 0);
        rx_byte = 8'hEF; rx_valid = 1'b1; lsr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; lsr_rd = 1'b0;
        chk("R7 set wins over clear", int'(lsr_overrun), 1);
        check_all("R3 second drop");
        for (int k = 0; k < 16; k++) begin
            pop_b();
            check_all("R2 drain after overrun");
        end

        // R8 add and remove in one cycle
        for (int k = 0; k < 5; k++) push_b(8'(k + 40));
        rx_byte = 8'h77; rx_valid = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rd_req = 1'b0;
        void'(mq.pop_front()); mq.push_back(8'h77);
        chk("R8 level unchanged", int'(rx_level), 5);
        while (mq.size() > 0) begin
            pop_b();
            check_all("R8 order");
        end

        // R9 clear drops a byte arriving in the same cycle
        for (int k = 0; k < 9; k++) push_b(8'(k + 60));
        check_all("R9 before clear");
        rx_byte = 8'h55; rx_valid = 1'b1;
        wr_ctrl(12'((4 << 9) | (2 << 7) | 2));
        rx_valid = 1'b0;
        chk("R9 level after clear", int'(rx_level), 0);
        chk("R9 flags after clear", int'(rx_full) + int'(data_ready), 0);
        check_all("R9 after clear");

        // R10 read on empty changes nothing
        pop_b();
        chk("R10 empty data", int'(rd_data), 0);
        chk("R10 empty level", int'(rx_level), 0);
        push_b(8'hA1);
        push_b(8'hB2);
        chk("R10 first byte", int'(rd_data), 8'hA1);
        pop_b();
        chk("R10 second byte", int'(rd_data), 8'hB2);
        check_all("R10 end");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule